// File: doc/BRIEF.md
# Asynchronous Host Memory Access Port

This block lets an external processor reach three internal targets through one parallel port with separate address and data lines. The targets are a small bank of 16-bit control registers, a connection memory that the host can read and write, and a data memory that the host can only read. The host qualifies an access with an active-low chip select and an active-low data strobe, and marks the direction with a read/write line that is high for a read. The port brings the strobes into the internal clock domain and decodes the 12-bit address. It then performs one single-cycle operation on the selected target and answers with an active-low transfer acknowledge, which stays asserted until the host releases the strobe.

The targets differ in width. Connection memory words are 12 bits wide: a write keeps only data bits 11:0, and a read returns zeros above bit 11. Data memory words are 8 bits wide, so a read returns zeros above bit 7. Host writes to the data memory are discarded. Addresses outside the three windows read as zero and ignore writes.

On the internal side, the switching fabric reads the connection memory through its own port and fills the data memory through a write port. The port never stores a host word into a connection memory location in the same clock in which the fabric reads that location. Instead, the host write waits one clock for each such clash.

Top module: `hport_top`

## Requirements
- R1: After reset `ack_n` is high, `data_oe` is low and every register on `cfg_regs` is zero.
- R2: An access starts when `ds_n` falls while `cs_n` is low. `ack_n` goes low on the 6th rising clock edge after `ds_n` falls: two synchronizer stages, one detection stage and a three-clock acknowledge delay. It then stays low while `ds_n` is low and returns high on the 3rd rising edge after `ds_n` rises.
- R3: While `cs_n` is high, asserting `ds_n` starts no access. `ack_n` stays high and no target changes.
- R4: `data_oe` is high exactly while `cs_n` is low, `ds_n` is low and `rd_wr_n` is high. This is a combinational function of the pins.
- R5: Addresses 0x000 to 0x007 select eight 16-bit read/write registers. Register i appears on `cfg_regs[16*i+15:16*i]`. Addresses 0x008 to 0x0FF read as zero and ignore writes.
- R6: Addresses 0x400 to 0x7FF select connection memory word addr[9:0]. A host write stores data bits 11:0 only.
- R7: A connection memory read returns the stored word in bits 11:0 with bits 15:12 zero. The fabric read port returns a word one clock after its enable is sampled.
- R8: Addresses 0x800 to 0xBFF select data memory byte addr[9:0]. A read returns the byte in bits 7:0 with bits 15:8 zero. The fabric write port stores a byte on the clock edge at which its enable is sampled.
- R9: A host write to the data memory window leaves the data memory unchanged.
- R10: Addresses 0x100 to 0x3FF and 0xC00 to 0xFFF read as zero and ignore writes.
- R11: When the fabric reads the connection memory word that a pending host write targets, the host write is deferred by one clock for each such cycle. The fabric read returns the old word, and `ack_n` is delayed by the same number of clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Host chip select, active low, asynchronous |
| ds_n | input | 1 | Host data strobe, active low, asynchronous |
| rd_wr_n | input | 1 | Direction: 1 read, 0 write |
| addr | input | 12 | Host address |
| wr_data | input | 16 | Host write data |
| rd_data | output | 16 | Host read data, valid while acknowledging a read |
| data_oe | output | 1 | Enable for the external tri-state data driver |
| ack_n | output | 1 | Transfer acknowledge, active low |
| fab_cm_rd_en | input | 1 | Fabric connection memory read enable |
| fab_cm_rd_addr | input | 10 | Fabric connection memory read index |
| fab_cm_rd_data | output | 12 | Fabric connection memory read word |
| fab_dm_we | input | 1 | Fabric data memory write enable |
| fab_dm_waddr | input | 10 | Fabric data memory write index |
| fab_dm_wdata | input | 8 | Fabric data memory write byte |
| cfg_regs | output | 128 | Flattened control register contents |

## Verification
The checker confirms on every cycle the behaviour that can be seen at a single edge. It checks that an acknowledge is held while the synchronized strobe stays low. It checks that the upper bits of the read bus are zero during any acknowledged read of the connection or data memory, and that the read bus is entirely zero for the unmapped top window. It also checks that a host connection memory write never shares a clock with a fabric read of the same index.

Only the bench scenarios can show timing and history. These cover the exact edge on which the acknowledge falls and rises, the extra clock inserted by a clash, and the fact that the fabric still reads the old word. They also cover masking of the written bits, and the discarded writes to the data memory, to the unused register addresses and while chip select is inactive. The bench shows these through later reads and through `cfg_regs`.

// File: rtl/hport_pkg.sv
package hport_pkg;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_REG  = 2'd1,
        TGT_CM   = 2'd2,
        TGT_DM   = 2'd3
    } tgt_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_ACK   = 2'd3
    } st_e;

endpackage

// File: rtl/hport_sync.sv
module hport_sync #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d};
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/hport_decode.sv
module hport_decode
    import hport_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int IDX_W   = 10,
    parameter int REG_WIN = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output tgt_e              tgt,
    output logic [IDX_W-1:0]  idx
);
    logic [1:0] win;

    assign win = addr[ADDR_W-1 -: 2];
    assign idx = addr[IDX_W-1:0];

    always_comb begin
        unique case (win)
            2'b00:   tgt = (addr[ADDR_W-3:REG_WIN] == '0) ? TGT_REG : TGT_NONE;
            2'b01:   tgt = TGT_CM;
            2'b10:   tgt = TGT_DM;
            default: tgt = TGT_NONE;
        endcase
    end
endmodule

// File: rtl/hport_ram.sv
module hport_ram #(
    parameter int W   = 12,
    parameter int AW  = 10,
    parameter int NRD = 1
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [W-1:0]      wdata,
    input  logic [NRD-1:0]    rd_en,
    input  logic [NRD*AW-1:0] rd_addr,
    output logic [NRD*W-1:0]  rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];
    logic [W-1:0] rd_q [NRD];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        for (int p = 0; p < NRD; p++) begin
            if (rd_en[p]) begin
                rd_q[p] <= mem[rd_addr[p*AW +: AW]];
            end
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rd_data[g*W +: W] = rd_q[g];
    end
endmodule

// File: rtl/hport_top.sv
module hport_top
    import hport_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int DATA_W      = 16,
    parameter int CM_W        = 12,
    parameter int DM_W        = 8,
    parameter int REG_COUNT   = 8,
    parameter int ACK_DELAY   = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cs_n,
    input  logic                        ds_n,
    input  logic                        rd_wr_n,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [DATA_W-1:0]           wr_data,
    output logic [DATA_W-1:0]           rd_data,
    output logic                        data_oe,
    output logic                        ack_n,
    input  logic                        fab_cm_rd_en,
    input  logic [ADDR_W-3:0]           fab_cm_rd_addr,
    output logic [CM_W-1:0]             fab_cm_rd_data,
    input  logic                        fab_dm_we,
    input  logic [ADDR_W-3:0]           fab_dm_waddr,
    input  logic [DM_W-1:0]             fab_dm_wdata,
    output logic [REG_COUNT*DATA_W-1:0] cfg_regs
);
    localparam int IDX_W     = ADDR_W - 2;
    localparam int REG_SEL_W = $clog2(REG_COUNT);
    localparam int CNT_W     = $clog2(ACK_DELAY);

    typedef struct packed {
        st_e                                st;
        logic [CNT_W-1:0]                   cnt;
        tgt_e                               tgt;
        logic [IDX_W-1:0]                   idx;
        logic [DATA_W-1:0]                  wdata;
        logic                               is_rd;
        logic                               ds_prev;
        logic [REG_COUNT-1:0][DATA_W-1:0]   regs;
    } state_t;

    localparam state_t STATE_RST = '{
        st:      ST_IDLE,
        cnt:     '0,
        tgt:     TGT_NONE,
        idx:     '0,
        wdata:   '0,
        is_rd:   1'b0,
        ds_prev: 1'b1,
        regs:    '0
    };

    state_t s_d, s_q;

    logic              cs_s, ds_s;
    tgt_e              dec_tgt;
    logic [IDX_W-1:0]  dec_idx;
    logic [IDX_W-1:0]  host_idx;
    logic              cm_host_we, cm_host_re, dm_host_re;
    logic              collide;
    logic              reg_hit;
    logic [REG_SEL_W-1:0] reg_sel;
    logic [2*CM_W-1:0] cm_rd_bus;
    logic [CM_W-1:0]   cm_host_rdata;
    logic [DM_W-1:0]   dm_host_rdata;
    logic [DATA_W-1:0] rd_val;

    hport_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
        .clk(clk), .rst_n(rst_n), .d(cs_n), .q(cs_s)
    );

    hport_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_ds (
        .clk(clk), .rst_n(rst_n), .d(ds_n), .q(ds_s)
    );

    hport_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .REG_WIN(8)) u_dec (
        .addr(addr), .tgt(dec_tgt), .idx(dec_idx)
    );

    assign host_idx = s_q.idx;
    assign reg_hit  = (s_q.tgt == TGT_REG) && (s_q.idx < IDX_W'(REG_COUNT));
    assign reg_sel  = s_q.idx[REG_SEL_W-1:0];
    assign collide  = (s_q.st == ST_ISSUE) && (s_q.tgt == TGT_CM) && !s_q.is_rd
                      && fab_cm_rd_en && (fab_cm_rd_addr == s_q.idx);

    always_comb begin
        s_d         = s_q;
        s_d.ds_prev = ds_s;
        cm_host_we  = 1'b0;
        cm_host_re  = 1'b0;
        dm_host_re  = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (!cs_s && !ds_s && s_q.ds_prev) begin
                    s_d.st    = ST_ISSUE;
                    s_d.tgt   = dec_tgt;
                    s_d.idx   = dec_idx;
                    s_d.wdata = wr_data;
                    s_d.is_rd = rd_wr_n;
                end
            end
            ST_ISSUE: begin
                if (!collide) begin
                    cm_host_we = (s_q.tgt == TGT_CM) && !s_q.is_rd;
                    cm_host_re = (s_q.tgt == TGT_CM) &&  s_q.is_rd;
                    dm_host_re = (s_q.tgt == TGT_DM) &&  s_q.is_rd;
                    if (reg_hit && !s_q.is_rd) begin
                        s_d.regs[reg_sel] = s_q.wdata;
                    end
                    s_d.st  = ST_WAIT;
                    s_d.cnt = CNT_W'(ACK_DELAY - 2);
                end
            end
            ST_WAIT: begin
                if (s_q.cnt == '0) begin
                    s_d.st = ST_ACK;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            ST_ACK: begin
                if (ds_s) begin
                    s_d.st = ST_IDLE;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= STATE_RST;
        end else begin
            s_q <= s_d;
        end
    end

    hport_ram #(.W(CM_W), .AW(IDX_W), .NRD(2)) u_cmem (
        .clk(clk),
        .we(cm_host_we),
        .waddr(s_q.idx),
        .wdata(s_q.wdata[CM_W-1:0]),
        .rd_en({fab_cm_rd_en, cm_host_re}),
        .rd_addr({fab_cm_rd_addr, s_q.idx}),
        .rd_data(cm_rd_bus)
    );

    assign cm_host_rdata  = cm_rd_bus[CM_W-1:0];
    assign fab_cm_rd_data = cm_rd_bus[2*CM_W-1:CM_W];

    hport_ram #(.W(DM_W), .AW(IDX_W), .NRD(1)) u_dmem (
        .clk(clk),
        .we(fab_dm_we),
        .waddr(fab_dm_waddr),
        .wdata(fab_dm_wdata),
        .rd_en(dm_host_re),
        .rd_addr(s_q.idx),
        .rd_data(dm_host_rdata)
    );

    always_comb begin
        unique case (s_q.tgt)
            TGT_REG: rd_val = reg_hit ? s_q.regs[reg_sel] : '0;
            TGT_CM:  rd_val = DATA_W'(cm_host_rdata);
            TGT_DM:  rd_val = DATA_W'(dm_host_rdata);
            default: rd_val = '0;
        endcase
    end

    assign rd_data  = (s_q.st == ST_ACK && s_q.is_rd) ? rd_val : '0;
    assign ack_n    = (s_q.st != ST_ACK);
    assign data_oe  = !cs_n && !ds_n && rd_wr_n;
    assign cfg_regs = s_q.regs;
endmodule

// File: rtl/hport_chk.sv
module hport_chk #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16,
    parameter int CM_W   = 12,
    parameter int DM_W   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ds_s,
    input logic              ack_n,
    input logic              rd_wr_n,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] rd_data,
    input logic              cm_host_we,
    input logic [ADDR_W-3:0] host_idx,
    input logic              fab_cm_rd_en,
    input logic [ADDR_W-3:0] fab_cm_rd_addr
);
    logic [1:0] win;
    assign win = addr[ADDR_W-1 -: 2];

    AST_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_n && !ds_s) |=> !ack_n); // R2

    AST_CM_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_n && rd_wr_n && win == 2'b01) |-> ((rd_data >> CM_W) == '0)); // R7

    AST_DM_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_n && rd_wr_n && win == 2'b10) |-> ((rd_data >> DM_W) == '0)); // R8

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_n && win == 2'b11) |-> (rd_data == '0)); // R10

    AST_NO_SAME_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_host_we && fab_cm_rd_en) |-> (fab_cm_rd_addr != host_idx)); // R11
endmodule

bind hport_top hport_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CM_W(CM_W), .DM_W(DM_W)
) u_chk (
    .clk(clk),
    .rst_n(rst_n),
    .ds_s(ds_s),
    .ack_n(ack_n),
    .rd_wr_n(rd_wr_n),
    .addr(addr),
    .rd_data(rd_data),
    .cm_host_we(cm_host_we),
    .host_idx(host_idx),
    .fab_cm_rd_en(fab_cm_rd_en),
    .fab_cm_rd_addr(fab_cm_rd_addr)
);

// File: tb/tb_hport_top.sv
module tb_hport_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cs_n = 1'b1;
    logic         ds_n = 1'b1;
    logic         rd_wr_n = 1'b1;
    logic [11:0]  addr = '0;
    logic [15:0]  wr_data = '0;
    logic [15:0]  rd_data;
    logic         data_oe;
    logic         ack_n;
    logic         fab_cm_rd_en = 1'b0;
    logic [9:0]   fab_cm_rd_addr = '0;
    logic [11:0]  fab_cm_rd_data;
    logic         fab_dm_we = 1'b0;
    logic [9:0]   fab_dm_waddr = '0;
    logic [7:0]   fab_dm_wdata = '0;
    logic [127:0] cfg_regs;

    int checks = 0;
    int errors = 0;

    logic [15:0] reg_m [8];
    logic [11:0] cm_m  [1024];
    logic [7:0]  dm_m  [1024];

    always #10 clk = ~clk;

    hport_top dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ds_n(ds_n), .rd_wr_n(rd_wr_n),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .data_oe(data_oe),
        .ack_n(ack_n), .fab_cm_rd_en(fab_cm_rd_en), .fab_cm_rd_addr(fab_cm_rd_addr),
        .fab_cm_rd_data(fab_cm_rd_data), .fab_dm_we(fab_dm_we),
        .fab_dm_waddr(fab_dm_waddr), .fab_dm_wdata(fab_dm_wdata), .cfg_regs(cfg_regs)
    );

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] model_read(input int a);
        if (a < 'h100)       return (a < 8) ? reg_m[a] : 16'h0000;
        else if (a >= 'h400 && a < 'h800) return {4'h0, cm_m[a - 'h400]};
        else if (a >= 'h800 && a < 'hC00) return {8'h00, dm_m[a - 'h800]};
        else                 return 16'h0000;
    endfunction

    task automatic model_write(input int a, input logic [15:0] d);
        if (a < 8)                        reg_m[a] = d;
        else if (a >= 'h400 && a < 'h800) cm_m[a - 'h400] = d[11:0];
    endtask

    // One host access; clash=1 makes the fabric read the same word during the issue clock.
    task automatic host_access(input string req, input logic [11:0] a, input logic [15:0] d,
                               input bit rd, input bit clash);
        int ack_k;
        logic [11:0] old_word;
        ack_k = clash ? 7 : 6;
        old_word = cm_m[a[9:0]];
        @(negedge clk);
        addr = a; wr_data = d; rd_wr_n = rd; cs_n = 1'b0;
        @(negedge clk);
        ds_n = 1'b0;
        #1;
        check({"R4 oe during access ", req}, data_oe, rd);
        for (int k = 1; k <= ack_k; k++) begin
            @(negedge clk);
            if (clash && k == 3) begin
                fab_cm_rd_en = 1'b1;
                fab_cm_rd_addr = a[9:0];
            end
            if (clash && k == 4) begin
                fab_cm_rd_en = 1'b0;
                check({"R11 fabric sees old word ", req}, fab_cm_rd_data, old_word);
            end
            check({"R2 ack timing ", req}, ack_n, (k >= ack_k) ? 1'b0 : 1'b1);
        end
        if (rd) check({req, " read data"}, rd_data, model_read(int'(a)));
        else    model_write(int'(a), d);
        ds_n = 1'b1;
        for (int j = 1; j <= 3; j++) begin
            @(negedge clk);
            check({"R2 ack release ", req}, ack_n, (j >= 3) ? 1'b1 : 1'b0);
        end
        cs_n = 1'b1;
        #1;
        check("R4 oe idle", data_oe, 1'b0);
    endtask

    task automatic fab_dm_write(input logic [9:0] i, input logic [7:0] v);
        @(negedge clk);
        fab_dm_we = 1'b1; fab_dm_waddr = i; fab_dm_wdata = v;
        @(negedge clk);
        fab_dm_we = 1'b0;
        dm_m[i] = v;
    endtask

    task automatic fab_cm_read(input string req, input logic [9:0] i);
        @(negedge clk);
        fab_cm_rd_en = 1'b1; fab_cm_rd_addr = i;
        @(negedge clk);
        fab_cm_rd_en = 1'b0;
        check(req, fab_cm_rd_data, cm_m[i]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog act=running exp=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) reg_m[i] = '0;
        for (int i = 0; i < 1024; i++) begin cm_m[i] = '0; dm_m[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ack after reset", ack_n, 1'b1);
        check("R1 oe after reset", data_oe, 1'b0);
        check("R1 regs after reset", cfg_regs, '0);

        // R5 registers
        host_access("R5 reg write", 12'h003, 16'hBEEF, 1'b0, 1'b0);
        check("R5 cfg_regs slice", cfg_regs[3*16 +: 16], 16'hBEEF);
        host_access("R5 reg read", 12'h003, 16'h0000, 1'b1, 1'b0);
        host_access("R5 reg write top", 12'h007, 16'h8001, 1'b0, 1'b0);
        host_access("R5 unused reg write", 12'h0F0, 16'h5555, 1'b0, 1'b0);
        host_access("R5 unused reg read", 12'h0F0, 16'h0000, 1'b1, 1'b0);
        check("R5 cfg_regs whole", cfg_regs,
              {reg_m[7], reg_m[6], reg_m[5], reg_m[4], reg_m[3], reg_m[2], reg_m[1], reg_m[0]});

        // R6 / R7 connection memory
        host_access("R6 cm write masked", 12'h405, 16'hF123, 1'b0, 1'b0);
        host_access("R7 cm read zero top", 12'h405, 16'h0000, 1'b1, 1'b0);
        fab_cm_read("R7 fabric read", 10'h005);
        host_access("R6 cm last write", 12'h7FF, 16'hAFFF, 1'b0, 1'b0);
        host_access("R7 cm last read", 12'h7FF, 16'h0000, 1'b1, 1'b0);

        // R8 / R9 data memory
        fab_dm_write(10'h007, 8'hA5);
        fab_dm_write(10'h000, 8'h3C);
        host_access("R8 dm read", 12'h807, 16'h0000, 1'b1, 1'b0);
        host_access("R8 dm first read", 12'h800, 16'h0000, 1'b1, 1'b0);
        host_access("R9 dm write ignored", 12'h807, 16'hFFFF, 1'b0, 1'b0);
        host_access("R9 dm unchanged", 12'h807, 16'h0000, 1'b1, 1'b0);

        // R10 unmapped windows
        host_access("R10 low gap write", 12'h300, 16'h1234, 1'b0, 1'b0);
        host_access("R10 low gap read", 12'h300, 16'h0000, 1'b1, 1'b0);
        host_access("R10 top write", 12'hC00, 16'h4321, 1'b0, 1'b0);
        host_access("R10 top read", 12'hC00, 16'h0000, 1'b1, 1'b0);
        check("R10 regs untouched", cfg_regs,
              {reg_m[7], reg_m[6], reg_m[5], reg_m[4], reg_m[3], reg_m[2], reg_m[1], reg_m[0]});

        // R11 clash deferral
        host_access("R11 prep", 12'h410, 16'h0ABC, 1'b0, 1'b0);
        host_access("R11 deferred write", 12'h410, 16'h0123, 1'b0, 1'b1);
        host_access("R11 readback", 12'h410, 16'h0000, 1'b1, 1'b0);

        // R3 strobe with chip select inactive
        @(negedge clk);
        addr = 12'h001; wr_data = 16'h1234; rd_wr_n = 1'b0; cs_n = 1'b1;
        @(negedge clk);
        ds_n = 1'b0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            check("R3 no ack without cs", ack_n, 1'b1);
        end
        rd_wr_n = 1'b1;
        #1;
        check("R4 oe low without cs", data_oe, 1'b0);
        ds_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R3 reg unchanged", cfg_regs[1*16 +: 16], 16'h0000);
        host_access("R3 reg readback", 12'h001, 16'h0000, 1'b1, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule